// File: doc/BRIEF.md
# Next Program Counter Unit

This block chooses the address of the next instruction for a 32-bit processor whose instructions all have the same 32-bit width and are stored at byte addresses four apart. It holds the program counter in a register, and it works out the address that follows from a decoded flow kind and from the operand values given with it. The kinds are plain sequential flow, two conditional branches that compare a pair of register values, a jump to a direct target, a jump that also saves a return address, and a jump to an address held in a register.

A branch target is the address after the current instruction plus a signed 16-bit word offset. A direct jump target keeps the top four bits of the address after the current instruction and takes every lower bit from a 26-bit word field. Every clock edge loads the chosen address into the program counter. The block also reports whether the flow left the sequential path. For the saving jump it raises a write strobe and gives a return address for the register file.

Top module: `nextPcUnit`

## Requirements
- R1: While `rst` is high the outputs `taken` and `linkWe` are 0, and a clock edge with `rst` high loads `pc` with 0x00000000.
- R2: Flow kind 0 (sequential), and the unused codes 6 and 7, give `nextPc = pc + 4` and `taken = 0`.
- R3: Flow kind 1 (branch when equal) gives `taken = 1` and `nextPc = pc + 4 + (sign-extended offset << 2)` when `opA == opB`. Otherwise it gives `taken = 0` and `nextPc = pc + 4`. An offset of 25 lands 100 bytes past `pc + 4`.
- R4: Flow kind 2 (branch when different) gives the same target as R3 when `opA != opB`, and `pc + 4` with `taken = 0` when the two values are equal.
- R5: The 16-bit branch offset is signed. 0xFFFF steps one word back from `pc + 4`, and 0x8000 steps 32768 words back.
- R6: Flow kind 3 (jump) gives `taken = 1` and `nextPc = {(pc+4)[31:28], jmpField, 2'b00}`. A field of 2500 gives byte address 10000 inside the current 256 MB region.
- R7: Flow kind 4 (jump with link) gives the same `nextPc` as R6 with `taken = 1`, and it also asserts `linkWe`.
- R8: Flow kind 5 (register jump) gives `taken = 1` and `nextPc = regTarget`, with all 32 bits, including the two low ones, passed on unchanged.
- R9: `linkWe` is 1 only for flow kind 4. `linkVal` always equals `pc + 4`.
- R10: Outside reset, every rising clock edge loads `pc` with the `nextPc` value that was present before the edge.
- R11: The region bits of a jump come from `pc + 4` and not from `pc`. A jump placed in the last word of a region lands in the next region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flowKind | input | 3 | Decoded flow kind (0 seq, 1 branch-equal, 2 branch-different, 3 jump, 4 jump-link, 5 register jump) |
| opA | input | 32 | First compared register value |
| opB | input | 32 | Second compared register value |
| brOffset | input | 16 | Signed branch offset in words |
| jmpField | input | 26 | Direct jump target field in words |
| regTarget | input | 32 | Register value for register jump |
| pc | output | 32 | Current program counter |
| nextPc | output | 32 | Address selected for the next instruction |
| taken | output | 1 | Flow leaves the sequential path |
| linkWe | output | 1 | Return-address write strobe |
| linkVal | output | 32 | Return address (pc + 4) |

## Verification
The assertions watch several rules on every cycle. A non-taken cycle must step `pc` by exactly four. A jump target must keep the region bits of `pc + 4` and must be word-aligned. A branch target must keep the alignment of `pc`. At most one target source may be selected at a time, and the link strobe may only appear together with a direct jump. Exact target arithmetic can only be shown by the bench's scenarios. These cover offsets of 25, −1 and −32768, the field value 2500, a jump from the last word of a region, an unaligned register target, the equal and different outcomes of both branches, and the return address.

// File: rtl/npcPkg.sv
package npcPkg;

  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_JMP  = 3'd3,
    FLOW_JAL  = 3'd4,
    FLOW_JREG = 3'd5
  } flowKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selBranch;
    logic selJump;
    logic selReg;
    logic taken;
    logic linkWe;
  } npcStrobes_t;

endpackage

// File: rtl/npcControl.sv
module npcControl
  import npcPkg::*;
(
  input  logic        rst,
  input  logic [2:0]  flowKind,
  input  logic        operandsEqual,
  output npcStrobes_t strb
);

  logic branchHit;
  logic isBeq;
  logic isBne;
  logic isJmp;
  logic isJal;
  logic isJreg;

  always_comb begin
    isBeq  = (flowKind == FLOW_BEQ);
    isBne  = (flowKind == FLOW_BNE);
    isJmp  = (flowKind == FLOW_JMP);
    isJal  = (flowKind == FLOW_JAL);
    isJreg = (flowKind == FLOW_JREG);
  end

  always_comb begin
    branchHit = (isBeq && operandsEqual) || (isBne && !operandsEqual);
  end

  always_comb begin
    strb.selBranch = branchHit;
    strb.selJump   = isJmp || isJal;
    strb.selReg    = isJreg;
    strb.taken     = !rst && (branchHit || isJmp || isJal || isJreg);
    strb.linkWe    = !rst && isJal;
  end

  // R9
  always_comb begin
    if (strb.linkWe) begin
      linkwe_kind_chk: assert (flowKind == FLOW_JAL);
    end
  end

  // R1
  always_comb begin
    if (rst) begin
      reset_quiet_chk: assert (!strb.taken && !strb.linkWe);
    end
  end

endmodule

// File: rtl/npcDatapath.sv
module npcDatapath
  import npcPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int FIELD_W = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  npcStrobes_t        strb,
  input  logic [ADDR_W-1:0]  opA,
  input  logic [ADDR_W-1:0]  opB,
  input  logic [OFF_W-1:0]   brOffset,
  input  logic [FIELD_W-1:0] jmpField,
  input  logic [ADDR_W-1:0]  regTarget,
  output logic               operandsEqual,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  nextPc,
  output logic [ADDR_W-1:0]  pcPlus4
);

  localparam int WORD_SHIFT = 2;
  localparam int EXT_W      = ADDR_W - OFF_W - WORD_SHIFT;
  localparam int REGION_W   = ADDR_W - FIELD_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] brDisp;
  logic [ADDR_W-1:0] brTarget;
  logic [ADDR_W-1:0] jmpTarget;
  logic [ADDR_W-1:0] pcReg;

  assign pc = pcReg;

  always_comb begin
    operandsEqual = (opA == opB);
  end

  always_comb begin
    pcPlus4 = pcReg + STEP;
  end

  // signed word offset scaled to bytes
  generate
    if (EXT_W > 0) begin : g_ext
      always_comb brDisp = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, {WORD_SHIFT{1'b0}}};
    end else begin : g_noext
      always_comb brDisp = {brOffset[ADDR_W-WORD_SHIFT-1:0], {WORD_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    brTarget = pcPlus4 + brDisp;
  end

  // region bits from the address after the jump
  generate
    if (REGION_W > 0) begin : g_region
      always_comb jmpTarget = {pcPlus4[ADDR_W-1 -: REGION_W], jmpField, {WORD_SHIFT{1'b0}}};
    end else begin : g_noregion
      always_comb jmpTarget = {jmpField[ADDR_W-WORD_SHIFT-1:0], {WORD_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    nextPc = pcPlus4;
    if (strb.selReg) begin
      nextPc = regTarget;
    end else if (strb.selJump) begin
      nextPc = jmpTarget;
    end else if (strb.selBranch) begin
      nextPc = brTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= '0;
    end else begin
      pcReg <= nextPc;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> pcReg == '0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.taken |=> pcReg == $past(pcReg) + STEP);

  // R6
  region_keep_chk: assert property (@(posedge clk) disable iff (rst)
    strb.selJump |-> (nextPc[ADDR_W-1 -: 4] == pcPlus4[ADDR_W-1 -: 4]) && (nextPc[1:0] == 2'b00));

  // R3
  branch_align_chk: assert property (@(posedge clk) disable iff (rst)
    strb.selBranch |-> nextPc[1:0] == pcReg[1:0]);

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.selBranch, strb.selJump, strb.selReg}));

  // R7
  link_jump_chk: assert property (@(posedge clk) disable iff (rst)
    strb.linkWe |-> strb.selJump && strb.taken);

endmodule

// File: rtl/nextPcUnit.sv
module nextPcUnit
  import npcPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 16,
  parameter int FIELD_W = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         flowKind,
  input  logic [ADDR_W-1:0]  opA,
  input  logic [ADDR_W-1:0]  opB,
  input  logic [OFF_W-1:0]   brOffset,
  input  logic [FIELD_W-1:0] jmpField,
  input  logic [ADDR_W-1:0]  regTarget,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  nextPc,
  output logic               taken,
  output logic               linkWe,
  output logic [ADDR_W-1:0]  linkVal
);

  npcStrobes_t strb;
  logic        operandsEqual;

  npcControl ctrl_i (
    .rst           (rst),
    .flowKind      (flowKind),
    .operandsEqual (operandsEqual),
    .strb          (strb)
  );

  npcDatapath #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .FIELD_W (FIELD_W)
  ) dp_i (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .opA           (opA),
    .opB           (opB),
    .brOffset      (brOffset),
    .jmpField      (jmpField),
    .regTarget     (regTarget),
    .operandsEqual (operandsEqual),
    .pc            (pc),
    .nextPc        (nextPc),
    .pcPlus4       (linkVal)
  );

  assign taken  = strb.taken;
  assign linkWe = strb.linkWe;

endmodule

// File: tb/nextPcUnit_tb.sv
module nextPcUnit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  flowKind;
  logic [31:0] opA, opB, regTarget;
  logic [15:0] brOffset;
  logic [25:0] jmpField;
  logic [31:0] pc, nextPc, linkVal;
  logic        taken, linkWe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nextPcUnit dut_i (
    .clk(clk), .rst(rst), .flowKind(flowKind), .opA(opA), .opB(opB),
    .brOffset(brOffset), .jmpField(jmpField), .regTarget(regTarget),
    .pc(pc), .nextPc(nextPc), .taken(taken), .linkWe(linkWe), .linkVal(linkVal)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] off;
    logic [25:0] fld;
    logic [31:0] rt;
    logic [31:0] start;
    logic [31:0] expNext;
    logic        expTaken;
    logic        expLink;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'd1, 32'd2, 16'd25,   26'd0,        32'd0,          32'h00000100, 32'h00000104, 1'b0, 1'b0},
    '{3'd1, 32'd7, 32'd7, 16'd25,   26'd0,        32'd0,          32'h00000100, 32'h00000168, 1'b1, 1'b0},
    '{3'd1, 32'd7, 32'd8, 16'd25,   26'd0,        32'd0,          32'h00000100, 32'h00000104, 1'b0, 1'b0},
    '{3'd2, 32'd3, 32'd9, 16'd25,   26'd0,        32'd0,          32'h00000200, 32'h00000268, 1'b1, 1'b0},
    '{3'd2, 32'd9, 32'd9, 16'd25,   26'd0,        32'd0,          32'h00000200, 32'h00000204, 1'b0, 1'b0},
    '{3'd1, 32'd5, 32'd5, 16'hFFFF, 26'd0,        32'd0,          32'h00000400, 32'h00000400, 1'b1, 1'b0},
    '{3'd1, 32'd0, 32'd0, 16'h8000, 26'd0,        32'd0,          32'h00100000, 32'h000E0004, 1'b1, 1'b0},
    '{3'd3, 32'd0, 32'd1, 16'd0,    26'd2500,     32'd0,          32'h00400000, 32'h00002710, 1'b1, 1'b0},
    '{3'd3, 32'd0, 32'd1, 16'd0,    26'h3FFFFFF,  32'd0,          32'h30000010, 32'h3FFFFFFC, 1'b1, 1'b0},
    '{3'd3, 32'd0, 32'd1, 16'd0,    26'd0,        32'd0,          32'h0FFFFFFC, 32'h10000000, 1'b1, 1'b0},
    '{3'd4, 32'd0, 32'd1, 16'd0,    26'd2500,     32'd0,          32'h00000500, 32'h00002710, 1'b1, 1'b1},
    '{3'd5, 32'd0, 32'd1, 16'd0,    26'd0,        32'h12345677,   32'h00000600, 32'h12345677, 1'b1, 1'b0},
    '{3'd6, 32'd4, 32'd4, 16'd25,   26'd9,        32'h0000ABC0,   32'h00000700, 32'h00000704, 1'b0, 1'b0},
    '{3'd7, 32'd4, 32'd4, 16'd25,   26'd9,        32'h0000ABC0,   32'h00000800, 32'h00000804, 1'b0, 1'b0}
  };

  function automatic string reqOf(input logic [2:0] k, input logic [15:0] off, input logic [31:0] start);
    if (k == 3'd1 && off[15]) return "R5";
    case (k)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return (start[27:0] == 28'hFFFFFFC) ? "R11" : "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] off, input logic [25:0] fld, input logic [31:0] rt);
    flowKind = k; opA = a; opB = b; brOffset = off; jmpField = fld; regTarget = rt;
  endtask

  // place pc at a value through a register jump
  task automatic setPc(input logic [31:0] value);
    @(negedge clk);
    drive(3'd5, 32'd0, 32'd1, 16'd0, 26'd0, value);
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1;
    drive(3'd4, 32'd0, 32'd0, 16'd0, 26'd5, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet and pc cleared during reset
    check32("R1", "pc in reset", pc, 32'h0);
    check32("R1", "taken in reset", {31'd0, taken}, 32'd0);
    check32("R1", "linkWe in reset", {31'd0, linkWe}, 32'd0);
    drive(3'd0, 32'd0, 32'd0, 16'd0, 26'd0, 32'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R10: step from zero
    check32("R10", "pc after first step", pc, 32'h4);

    for (int i = 0; i < NV; i++) begin
      setPc(VECS[i].start);
      @(negedge clk);
      drive(VECS[i].kind, VECS[i].a, VECS[i].b, VECS[i].off, VECS[i].fld, VECS[i].rt);
      #1;
      check32(reqOf(VECS[i].kind, VECS[i].off, VECS[i].start), "nextPc", nextPc, VECS[i].expNext);
      check32(reqOf(VECS[i].kind, VECS[i].off, VECS[i].start), "taken", {31'd0, taken}, {31'd0, VECS[i].expTaken});
      check32("R9", "linkWe", {31'd0, linkWe}, {31'd0, VECS[i].expLink});
      check32("R9", "linkVal", linkVal, VECS[i].start + 32'd4);
      @(posedge clk);
      #1;
      check32("R10", "pc loaded", pc, VECS[i].expNext);
    end

    // R1: reset in mid-run clears pc
    setPc(32'h00ABCDE0);
    @(negedge clk);
    rst = 1'b1;
    drive(3'd3, 32'd0, 32'd0, 16'd0, 26'd77, 32'd0);
    #1;
    check32("R1", "taken during late reset", {31'd0, taken}, 32'd0);
    @(posedge clk);
    #1;
    check32("R1", "pc after late reset", pc, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    drive(3'd0, 32'd0, 32'd0, 16'd0, 26'd0, 32'd0);

    // R8: register jump keeps low bits, then sequential continues from there
    setPc(32'hFFFFFFFE);
    @(negedge clk);
    check32("R8", "odd pc kept", pc, 32'hFFFFFFFE);
    drive(3'd0, 32'd0, 32'd0, 16'd0, 26'd0, 32'd0);
    @(posedge clk);
    #1;
    check32("R2", "wraparound step", pc, 32'h00000002);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule